// File: doc/BRIEF.md
# Core Idle State Sequencer

This block is the per-core controller that moves a processor core between normal running and two idle depths. In the light idle depth (nap) it holds instruction fetch and execution and gates only the clocks of the execution engines, so the caches keep their clocks and power and stay coherent with no purge. In the deep idle depth (sleep) it gates the clock of the whole core chiplet, turns the PLL off and removes power from the cache arrays.

Entry to either depth first asks the core to quiesce and gates nothing until the core reports that it has quiesced. Leaving sleep follows a fixed restart order: the PLL is enabled and the sequencer waits for lock, then cache array power is enabled and it waits for power-good, then the clocks come back and the core resumes. Each wait has a programmable cycle limit. If a limit runs out, a sticky error is raised and the core is parked in sleep. A 2-bit idle-state report is exported so that voltage and frequency control can follow the idle depth without software.

Top module: `core_idle_seq`

## Requirements
- R1: After reset the block is running: `fetch_hold`=0, `exec_clk_en`, `chiplet_clk_en`, `pll_en` and `array_pwr_en` are all 1, `idle_state`=00 and `seq_error`=0. Reset is the only thing that clears `seq_error`.
- R2: A nap or sleep request seen while running raises `fetch_hold` and sets `idle_state` to 11 on the next cycle. No enable drops until `quiesce_done` has been seen. When both requests arrive in the same cycle, sleep is taken.
- R3: Nap is entered on the cycle after `quiesce_done`. In nap, `exec_clk_en`=0 while `chiplet_clk_en`, `pll_en` and `array_pwr_en` stay 1 and `idle_state`=01. A wake event in nap returns the block to running on the next cycle.
- R4: Sleep is entered on the cycle after `quiesce_done`. In sleep all four enables are 0, `fetch_hold`=1 and `idle_state`=10.
- R5: A wake event in sleep first sets `pll_en` alone. `array_pwr_en` rises on the cycle after `pll_lock` is seen. The clocks rise on the cycle after `array_pwr_good` is seen. Running resumes (`fetch_hold`=0) one cycle later.
- R6: Nap and sleep requests are ignored unless the block is running, and wake events are ignored while it is running.
- R7: The lock wait (`lock_limit`) and the power wait (`pwr_limit`) each time out when their input is still low in the (limit+1)-th cycle of the wait. A timeout sets `seq_error` and returns the block to sleep. While `seq_error` is set, the block stays in sleep and ignores wake events.
- R8: A wake event that arrives while the block is quiescing for an idle depth is held. The block completes entry into that depth (one cycle reported at 01 or 10) and then starts the exit.
- R9: `idle_state` encodes running as 00, nap as 01, sleep as 10, and any transition (quiescing, restart steps, resume) as 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nap_req | input | 1 | Request for the light idle depth |
| sleep_req | input | 1 | Request for the deep idle depth |
| wake_evt | input | 1 | Wake event |
| quiesce_done | input | 1 | Core reports fetch and execution have stopped |
| pll_lock | input | 1 | PLL reports lock |
| array_pwr_good | input | 1 | Cache array supply reports power-good |
| lock_limit | input | TW | Cycle limit for the lock wait |
| pwr_limit | input | TW | Cycle limit for the power-good wait |
| fetch_hold | output | 1 | Hold instruction fetch and execution |
| exec_clk_en | output | 1 | Clock enable of the execution engines |
| chiplet_clk_en | output | 1 | Clock enable of the rest of the chiplet, caches included |
| pll_en | output | 1 | PLL enable |
| array_pwr_en | output | 1 | Cache array power enable |
| idle_state | output | 2 | Idle-state report for voltage and frequency control |
| seq_error | output | 1 | Sticky restart timeout flag |

## Verification
The bench goes after the following corner cases:
- A quiesce that arrives late. A design that gated early would drop `exec_clk_en` while the core was still executing.
- Simultaneous nap and sleep requests. A design with the wrong priority would report 01 instead of 10.
- A wake that lands while the block is quiescing. A design that dropped it would leave the core asleep, and one that acted on it at once would leave clocks partly gated.
- Both restart waits run to exactly their limit. A design that is off by one would raise the error a cycle early or a cycle late, and one whose flag is not sticky would restart on a later wake.

// File: rtl/idle_seq_pkg.sv
// Shared types for the core idle sequencer.
// Assumes: state encoding is private to the block; only the idle report codes are seen outside.
package idle_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_NAP_Q  = 3'd1,
        ST_NAP    = 3'd2,
        ST_SLP_Q  = 3'd3,
        ST_SLEEP  = 3'd4,
        ST_PLL_UP = 3'd5,
        ST_ARR_UP = 3'd6,
        ST_RESUME = 3'd7
    } seq_state_t;

    localparam logic [1:0] IDLE_RUN   = 2'b00;
    localparam logic [1:0] IDLE_NAP   = 2'b01;
    localparam logic [1:0] IDLE_SLEEP = 2'b10;
    localparam logic [1:0] IDLE_TRANS = 2'b11;

    typedef struct packed {
        logic       hold_core;
        logic       exec_clk;
        logic       chiplet_clk;
        logic       pll_on;
        logic       array_pwr;
        logic [1:0] idle;
    } seq_out_t;

endpackage

// File: rtl/step_timer.sv
// Wait-window counter for the restart steps.
// Counts cycles while a wait is active and reports expiry on the cycle the
// count equals the limit. Assumes: restart is high on every state change.
module step_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          restart,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    // count cycles inside one wait, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !active) begin
            cnt_q <= '0;
        end else if (cnt_q != limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // the window is used up when the count reaches the limit
    always_comb begin
        expired = active && (cnt_q == limit);
    end

    // r7: the counter never jumps past its limit while a wait is held
    p_cnt_within_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !restart && $stable(limit) && (cnt_q <= limit)) |=> (cnt_q <= limit));

endmodule

// File: rtl/wake_catch.sv
// Holds a wake event that arrives while the core is quiescing.
// The held wake is spent in the first cycle of the idle depth, where the
// state machine acts on it. Assumes: wake_evt is a level or pulse, both accepted.
module wake_catch
    import idle_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state_q,
    input  logic       wake_evt,
    output logic       wake_now
);

    logic pend_q;
    logic in_entry;
    logic in_depth;

    // decode the entry and resting states
    always_comb begin
        in_entry = (state_q == ST_NAP_Q) || (state_q == ST_SLP_Q);
        in_depth = (state_q == ST_NAP)   || (state_q == ST_SLEEP);
    end

    // remember a wake seen during entry until the depth is reached
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (in_entry && wake_evt) begin
            pend_q <= 1'b1;
        end else if (in_depth) begin
            pend_q <= 1'b0;
        end
    end

    // effective wake seen by the state machine
    always_comb begin
        wake_now = wake_evt || pend_q;
    end

    // r8: a held wake only exists during entry or on the first cycle of the depth
    p_pend_scope_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (in_entry || in_depth));

endmodule

// File: rtl/idle_fsm.sv
// State machine of the idle sequencer.
// Walks run -> quiesce -> nap/sleep and the ordered sleep exit
// (PLL lock, then array power, then resume). A timeout parks it in sleep and
// sets a sticky error. Assumes: expired comes from a timer cleared on every
// state change.
module idle_fsm
    import idle_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nap_req,
    input  logic       sleep_req,
    input  logic       wake_now,
    input  logic       quiesce_done,
    input  logic       pll_lock,
    input  logic       array_pwr_good,
    input  logic       expired,
    output seq_state_t state_q,
    output seq_state_t state_nxt,
    output logic       err_q
);

    logic set_err;

    // next state and timeout detection
    always_comb begin
        state_nxt = state_q;
        set_err   = 1'b0;
        case (state_q)
            ST_RUN: begin
                if (sleep_req) begin
                    state_nxt = ST_SLP_Q;
                end else if (nap_req) begin
                    state_nxt = ST_NAP_Q;
                end
            end
            ST_NAP_Q: begin
                if (quiesce_done) begin
                    state_nxt = ST_NAP;
                end
            end
            ST_NAP: begin
                if (wake_now) begin
                    state_nxt = ST_RUN;
                end
            end
            ST_SLP_Q: begin
                if (quiesce_done) begin
                    state_nxt = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (wake_now && !err_q) begin
                    state_nxt = ST_PLL_UP;
                end
            end
            ST_PLL_UP: begin
                if (pll_lock) begin
                    state_nxt = ST_ARR_UP;
                end else if (expired) begin
                    state_nxt = ST_SLEEP;
                    set_err   = 1'b1;
                end
            end
            ST_ARR_UP: begin
                if (array_pwr_good) begin
                    state_nxt = ST_RESUME;
                end else if (expired) begin
                    state_nxt = ST_SLEEP;
                    set_err   = 1'b1;
                end
            end
            ST_RESUME: begin
                state_nxt = ST_RUN;
            end
            default: begin
                state_nxt = ST_RUN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_nxt;
        end
    end

    // sticky timeout flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (set_err) begin
            err_q <= 1'b1;
        end
    end

    // r6: requests made in nap without a wake leave the block in nap
    p_req_ignored_in_nap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NAP && !wake_now && (nap_req || sleep_req)) |=> (state_q == ST_NAP));

    // r4: sleep is only reached from sleep entry or from a failed restart step
    p_sleep_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SLEEP) && !$stable(state_q)) |->
            ($past(state_q) == ST_SLP_Q || $past(state_q) == ST_PLL_UP || $past(state_q) == ST_ARR_UP));

endmodule

// File: rtl/idle_out_decode.sv
// Decodes the sequencer state into enables and the idle report.
// Outputs depend on the state register only, so they are glitch-free per cycle.
module idle_out_decode
    import idle_seq_pkg::*;
(
    input  seq_state_t state_q,
    output seq_out_t   outs
);

    // one output word per state
    always_comb begin
        case (state_q)
            ST_RUN:    outs = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, IDLE_RUN};
            ST_NAP:    outs = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, IDLE_NAP};
            ST_SLEEP:  outs = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, IDLE_SLEEP};
            ST_PLL_UP: outs = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, IDLE_TRANS};
            ST_ARR_UP: outs = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, IDLE_TRANS};
            default:   outs = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, IDLE_TRANS};
        endcase
    end

endmodule

// File: rtl/core_idle_seq.sv
// Core idle state sequencer, top level.
// Joins the state machine, the wake holder, the restart-wait timer and the
// output decode. Assumes: all inputs are synchronous to clk; the limits
// are held steady during a restart.
module core_idle_seq
    import idle_seq_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nap_req,
    input  logic          sleep_req,
    input  logic          wake_evt,
    input  logic          quiesce_done,
    input  logic          pll_lock,
    input  logic          array_pwr_good,
    input  logic [TW-1:0] lock_limit,
    input  logic [TW-1:0] pwr_limit,
    output logic          fetch_hold,
    output logic          exec_clk_en,
    output logic          chiplet_clk_en,
    output logic          pll_en,
    output logic          array_pwr_en,
    output logic [1:0]    idle_state,
    output logic          seq_error
);

    seq_state_t    state_q;
    seq_state_t    state_nxt;
    logic          wake_now;
    logic          expired;
    logic          wait_active;
    logic          wait_restart;
    logic [TW-1:0] wait_limit;
    seq_out_t      outs;

    // select the window that applies to the current restart step
    always_comb begin
        wait_active  = (state_q == ST_PLL_UP) || (state_q == ST_ARR_UP);
        wait_restart = (state_nxt != state_q);
        wait_limit   = (state_q == ST_PLL_UP) ? lock_limit : pwr_limit;
    end

    idle_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .nap_req        (nap_req),
        .sleep_req      (sleep_req),
        .wake_now       (wake_now),
        .quiesce_done   (quiesce_done),
        .pll_lock       (pll_lock),
        .array_pwr_good (array_pwr_good),
        .expired        (expired),
        .state_q        (state_q),
        .state_nxt      (state_nxt),
        .err_q          (seq_error)
    );

    wake_catch u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (state_q),
        .wake_evt (wake_evt),
        .wake_now (wake_now)
    );

    step_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (wait_active),
        .restart (wait_restart),
        .limit   (wait_limit),
        .expired (expired)
    );

    idle_out_decode u_dec (
        .state_q (state_q),
        .outs    (outs)
    );

    // drive the ports from the decoded word
    always_comb begin
        fetch_hold     = outs.hold_core;
        exec_clk_en    = outs.exec_clk;
        chiplet_clk_en = outs.chiplet_clk;
        pll_en         = outs.pll_on;
        array_pwr_en   = outs.array_pwr;
        idle_state     = outs.idle;
    end

    // r2: execution clocks are only gated after the core reported quiescence
    p_gate_after_quiesce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(exec_clk_en) |-> $past(quiesce_done));

    // r3: nap keeps caches clocked and powered and the PLL running
    p_nap_keeps_caches_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_state == IDLE_NAP) |-> (chiplet_clk_en && array_pwr_en && pll_en && !exec_clk_en));

    // r5: array power returns only after lock was seen
    p_array_after_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(array_pwr_en) |-> $past(pll_lock));

    // r5: chiplet clock returns only after array power-good was seen
    p_clock_after_power_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chiplet_clk_en) |-> $past(array_pwr_good));

    // r7: the error flag is sticky
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_error |=> seq_error);

    // r7: a flagged block is parked in sleep
    p_err_parks_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_error |-> (idle_state == IDLE_SLEEP));

endmodule

// File: tb/core_idle_seq_tb.sv
// Bench for core_idle_seq: a behavioural reference model stepped on every
// clock and compared at each falling edge, plus directed checks per requirement.
module core_idle_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nap_req = 1'b0;
    logic          sleep_req = 1'b0;
    logic          wake_evt = 1'b0;
    logic          quiesce_done = 1'b0;
    logic          pll_lock = 1'b0;
    logic          array_pwr_good = 1'b0;
    logic [TW-1:0] lock_limit = 8'd5;
    logic [TW-1:0] pwr_limit = 8'd4;
    logic          fetch_hold;
    logic          exec_clk_en;
    logic          chiplet_clk_en;
    logic          pll_en;
    logic          array_pwr_en;
    logic [1:0]    idle_state;
    logic          seq_error;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit started = 0;
    bit finished = 0;

    // model: phase 0 run,1 nap entry,2 nap,3 sleep entry,4 sleep,5 lock wait,6 power wait,7 resume
    int ph = 0;
    int nph;
    int mcnt = 0;
    bit merr = 0;
    bit mpend = 0;

    core_idle_seq #(.TW(TW)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .nap_req        (nap_req),
        .sleep_req      (sleep_req),
        .wake_evt       (wake_evt),
        .quiesce_done   (quiesce_done),
        .pll_lock       (pll_lock),
        .array_pwr_good (array_pwr_good),
        .lock_limit     (lock_limit),
        .pwr_limit      (pwr_limit),
        .fetch_hold     (fetch_hold),
        .exec_clk_en    (exec_clk_en),
        .chiplet_clk_en (chiplet_clk_en),
        .pll_en         (pll_en),
        .array_pwr_en   (array_pwr_en),
        .idle_state     (idle_state),
        .seq_error      (seq_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // expected {hold, exec, chiplet, pll, array, idle} for a model phase
    function automatic logic [6:0] exp_word(input int p);
        case (p)
            0:       return {1'b0, 4'b1111, 2'b00};
            2:       return {1'b1, 4'b0111, 2'b01};
            4:       return {1'b1, 4'b0000, 2'b10};
            5:       return {1'b1, 4'b0010, 2'b11};
            6:       return {1'b1, 4'b0011, 2'b11};
            default: return {1'b1, 4'b1111, 2'b11};
        endcase
    endfunction

    function automatic string phase_tag(input int p);
        case (p)
            0:       return "R1";
            1, 3:    return "R2";
            2:       return "R3";
            4:       return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // reference model, advanced on each rising edge from the bench-driven inputs
    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (!rst_n) begin
            ph = 0; mcnt = 0; merr = 0; mpend = 0;
        end else begin
            nph = ph;
            case (ph)
                0: if (sleep_req) nph = 3; else if (nap_req) nph = 1;
                1: begin if (wake_evt) mpend = 1; if (quiesce_done) nph = 2; end
                2: begin if (wake_evt || mpend) nph = 0; mpend = 0; end
                3: begin if (wake_evt) mpend = 1; if (quiesce_done) nph = 4; end
                4: begin if (!merr && (wake_evt || mpend)) nph = 5; mpend = 0; end
                5: if (pll_lock) nph = 6; else if (mcnt == int'(lock_limit)) begin nph = 4; merr = 1; end
                6: if (array_pwr_good) nph = 7; else if (mcnt == int'(pwr_limit)) begin nph = 4; merr = 1; end
                default: nph = 0;
            endcase
            if (nph != ph) mcnt = 0;
            else if (ph == 5 && mcnt != int'(lock_limit)) mcnt++;
            else if (ph == 6 && mcnt != int'(pwr_limit)) mcnt++;
            ph = nph;
        end
    end

    // compare every output with the model on each falling edge (R9 covers the report)
    always @(negedge clk) begin
        if (started && !finished) begin
            chk({fetch_hold, exec_clk_en, chiplet_clk_en, pll_en, array_pwr_en} == exp_word(ph)[6:2],
                phase_tag(ph), {fetch_hold, exec_clk_en, chiplet_clk_en, pll_en, array_pwr_en},
                exp_word(ph)[6:2]);
            chk(idle_state == exp_word(ph)[1:0], "R9", idle_state, exp_word(ph)[1:0]);
            chk(seq_error == merr, "R7", seq_error, merr);
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 5000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // go into sleep from run with immediate quiesce
    task automatic enter_sleep();
        sleep_req = 1; step(1); sleep_req = 0;
        quiesce_done = 1; step(1); quiesce_done = 0;
    endtask

    initial begin
        step(3);
        chk(idle_state == 2'b00 && exec_clk_en && pll_en && array_pwr_en && !fetch_hold,
            "R1 reset state", idle_state, 0);
        chk(seq_error == 0, "R1 error clear", seq_error, 0);
        rst_n = 1;
        step(1);

        // wake in run has no effect
        wake_evt = 1; step(1); wake_evt = 0;
        chk(idle_state == 2'b00 && !fetch_hold, "R6 wake in run", idle_state, 0);

        // nap with late quiesce
        nap_req = 1; step(1); nap_req = 0;
        chk(fetch_hold && idle_state == 2'b11, "R2 quiesce start", idle_state, 3);
        step(2);
        chk(exec_clk_en == 1, "R2 no gate before quiesce", exec_clk_en, 1);
        quiesce_done = 1; step(1); quiesce_done = 0;
        chk(idle_state == 2'b01 && !exec_clk_en && chiplet_clk_en && array_pwr_en,
            "R3 nap outputs", idle_state, 1);
        sleep_req = 1; step(1); sleep_req = 0;
        chk(idle_state == 2'b01, "R6 request in nap", idle_state, 1);
        wake_evt = 1; step(1); wake_evt = 0;
        chk(idle_state == 2'b00 && exec_clk_en, "R3 nap exit", idle_state, 0);

        // both requests: sleep wins
        nap_req = 1; sleep_req = 1; step(1); nap_req = 0; sleep_req = 0;
        quiesce_done = 1; step(1); quiesce_done = 0;
        chk(idle_state == 2'b10, "R2 sleep priority", idle_state, 2);
        chk({exec_clk_en, chiplet_clk_en, pll_en, array_pwr_en} == 4'b0000, "R4 sleep gates all",
            {exec_clk_en, chiplet_clk_en, pll_en, array_pwr_en}, 0);

        // ordered exit
        wake_evt = 1; step(1); wake_evt = 0;
        chk(pll_en && !array_pwr_en && !chiplet_clk_en, "R5 PLL first", array_pwr_en, 0);
        step(2);
        chk(!array_pwr_en, "R5 waits for lock", array_pwr_en, 0);
        pll_lock = 1; step(1);
        chk(array_pwr_en && !chiplet_clk_en, "R5 array after lock", chiplet_clk_en, 0);
        step(1);
        chk(!chiplet_clk_en, "R5 waits for power-good", chiplet_clk_en, 0);
        array_pwr_good = 1; step(1);
        chk(chiplet_clk_en && exec_clk_en && fetch_hold, "R5 clocks back", fetch_hold, 1);
        step(1);
        chk(idle_state == 2'b00 && !fetch_hold, "R5 resumed", idle_state, 0);
        pll_lock = 0; array_pwr_good = 0;

        // wake during sleep entry
        sleep_req = 1; step(1); sleep_req = 0;
        wake_evt = 1; step(1); wake_evt = 0;
        chk(idle_state == 2'b11, "R8 still quiescing", idle_state, 3);
        quiesce_done = 1; step(1); quiesce_done = 0;
        chk(idle_state == 2'b10 && !pll_en, "R8 entry completed", idle_state, 2);
        step(1);
        chk(pll_en && idle_state == 2'b11, "R8 exit begun", pll_en, 1);
        pll_lock = 1; array_pwr_good = 1; step(3);
        chk(idle_state == 2'b00, "R8 back to run", idle_state, 0);
        pll_lock = 0; array_pwr_good = 0;

        // wake together with quiesce during nap entry
        nap_req = 1; step(1); nap_req = 0;
        wake_evt = 1; quiesce_done = 1; step(1); wake_evt = 0; quiesce_done = 0;
        chk(idle_state == 2'b01, "R8 nap entry completed", idle_state, 1);
        step(1);
        chk(idle_state == 2'b00, "R8 nap exit", idle_state, 0);

        // lock timeout
        lock_limit = 8'd3;
        enter_sleep();
        wake_evt = 1; step(1); wake_evt = 0;
        step(3);
        chk(!seq_error && pll_en, "R7 not before limit", seq_error, 0);
        step(1);
        chk(seq_error && idle_state == 2'b10 && !pll_en, "R7 lock timeout", seq_error, 1);
        wake_evt = 1; step(1); wake_evt = 0;
        chk(idle_state == 2'b10 && !pll_en, "R7 wake ignored after error", idle_state, 2);
        step(3);
        chk(seq_error, "R7 sticky", seq_error, 1);

        rst_n = 0; step(2); rst_n = 1; step(1);
        chk(!seq_error && idle_state == 2'b00, "R1 reset clears error", seq_error, 0);

        // power-good timeout
        pwr_limit = 8'd2;
        enter_sleep();
        wake_evt = 1; pll_lock = 1; step(1); wake_evt = 0;
        step(1);
        pll_lock = 0;
        step(2);
        chk(!seq_error && array_pwr_en, "R7 power wait running", seq_error, 0);
        step(1);
        chk(seq_error && idle_state == 2'b10 && !array_pwr_en, "R7 power timeout", seq_error, 1);
        step(2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule